// File: doc/BRIEF.md
# Prioritized DMA Channel Trigger Arbiter

This block sits in front of a single shared DMA transfer engine. It collects activation triggers for a set of channels and decides which channel the engine works on next. A trigger pulse on an enabled channel is stored as a pending request. The request stays stored until the engine reports that the channel's trigger-scoped work is finished. The engine is never starved of work that arrived while it was busy.

Each channel is configured with a 2-bit priority level, where 0 is the most urgent, an enable bit and a preemptable flag. The block first finds the most urgent level that has an eligible pending channel. Inside that level it picks a channel round-robin, using one rotation pointer per level. While a preemptable channel is active, a pending channel at a strictly more urgent level takes the engine over at the next single-transfer boundary. The displaced channel keeps its pending request. The result is a registered one-hot grant with a valid bit.

Top module: `dta_trigger_arbiter`

## Requirements
- R1: A trigger on an enabled channel sets that channel's pending request at the clock edge that samples it. When the engine is idle, the grant for that request appears at the following edge.
- R2: At most one channel is granted. `grant_o` is one-hot while `grant_vld_o` is 1 and all zeros while `grant_vld_o` is 0.
- R3: Whenever a grant is issued, the winner comes from the eligible pending channels with the numerically smallest priority level (level 0 is the highest). Here "eligible" means enabled and not the currently granted channel.
- R4: Within one level, the search starts at the channel index that follows the channel last granted at that level, wrapping from the top index to 0. That level's pointer moves only when a grant at that level is issued. All pointers start at 0.
- R5: When `xfer_bound_i` is 1, the active channel is preemptable, and an eligible pending channel has a strictly smaller level number, the grant moves to that channel at the same edge. If the candidate is only at an equal level, nothing changes.
- R6: An active channel that is not preemptable keeps the grant across boundary pulses until `xfer_done_i` is 1 or it is disabled. With no done, boundary or disable, the grant never changes.
- R7: `xfer_done_i` takes precedence over `xfer_bound_i`. At that edge it clears the active channel's pending request and moves the grant to the next winner, or drops `grant_vld_o` when nothing is eligible.
- R8: A preempted channel keeps its pending request and is granted again later through normal arbitration.
- R9: A disabled channel ignores triggers, loses its pending request at the next edge, and never wins. Disabling the active channel releases the grant at the next edge, in the same way as a done.
- R10: Reset clears all pending requests, the grant, the valid bit and the rotation pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | N_CH | Per-channel activation trigger pulses |
| chan_en_i | input | N_CH | Per-channel enable |
| chan_prio_i | input | 2*N_CH | Per-channel priority level, channel c in bits [2c+1:2c], 0 highest |
| chan_preempt_i | input | N_CH | Per-channel preemptable flag |
| xfer_bound_i | input | 1 | Engine pulse: a single-element transfer just completed |
| xfer_done_i | input | 1 | Engine pulse: the active channel's trigger-scoped work is done |
| grant_o | output | N_CH | Registered one-hot grant to the engine |
| grant_vld_o | output | 1 | Grant valid |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot or empty, in step with the valid bit;
- the grant holds when no done, boundary or disable event occurs;
- a non-preemptable channel is never displaced before done;
- every done is followed by a change of grant or a drop of valid;
- every newly granted channel was enabled.

Some behaviours only the bench's scenarios can show:
- which channel wins, because that depends on level order and the per-level rotation history;
- that an equal-level candidate does not preempt;
- that a preempted channel comes back;
- that a disabled or reset channel leaves no latent request behind.

// File: rtl/dta_pkg.sv
package dta_pkg;
  localparam int PRIO_W  = 2;
  localparam int NUM_LVL = 1 << PRIO_W;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/dta_pending.sv
// Per-channel pending request store.
module dta_pending #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] trig_i,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] pend_o
);
  logic [N_CH-1:0] pend_q, pend_d;
  logic            upd;

  always_comb begin
    pend_d = (pend_q & ~clr_i & en_i) | (trig_i & en_i);
    upd    = (|trig_i) | (|clr_i) | (|(pend_q & ~en_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dta_level_sel.sv
// Finds the most urgent level holding an eligible request.
module dta_level_sel
  import dta_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic [N_CH-1:0]        elig_i,
  input  logic [N_CH*PRIO_W-1:0] prio_i,
  output prio_t                  lvl_o,
  output logic [N_CH-1:0]        lvl_req_o,
  output logic                   any_o
);
  logic [NUM_LVL-1:0][N_CH-1:0] by_lvl;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign by_lvl[l][c] = elig_i[c] && (prio_i[c*PRIO_W +: PRIO_W] == prio_t'(l));
    end
  end

  always_comb begin
    lvl_o     = prio_t'(NUM_LVL - 1);
    lvl_req_o = '0;
    any_o     = |elig_i;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (|by_lvl[l]) begin
        lvl_o     = prio_t'(l);
        lvl_req_o = by_lvl[l];
      end
    end
  end
endmodule

// File: rtl/dta_rr_pick.sv
// Circular first-set search starting at a pointer.
module dta_rr_pick #(
  parameter int N_CH  = 8,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= N_CH) j = j - N_CH;
      if (!hit_o && req_i[j]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/dta_trigger_arbiter.sv
// Trigger arbiter for one shared DMA transfer engine.
module dta_trigger_arbiter
  import dta_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        trig_i,
  input  logic [N_CH-1:0]        chan_en_i,
  input  logic [N_CH*PRIO_W-1:0] chan_prio_i,
  input  logic [N_CH-1:0]        chan_preempt_i,
  input  logic                   xfer_bound_i,
  input  logic                   xfer_done_i,
  output logic [N_CH-1:0]        grant_o,
  output logic                   grant_vld_o
);
  logic [N_CH-1:0] pend, clr, elig, lvl_req;
  logic [N_CH-1:0] grant_q, grant_d;
  logic            vld_q, vld_d;
  logic [NUM_LVL-1:0][IDX_W-1:0] ptr_q, ptr_d;
  prio_t           win_lvl, act_lvl;
  logic            any_elig, win_hit;
  logic [IDX_W-1:0] win_idx, win_nxt;
  logic            act_en, act_pre, release_c, preempt_c, issue, upd;

  assign clr = (vld_q && xfer_done_i) ? grant_q : '0;

  dta_pending #(.N_CH(N_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .en_i(chan_en_i),
    .clr_i(clr), .pend_o(pend)
  );

  assign elig = pend & chan_en_i & ~(vld_q ? grant_q : '0);

  dta_level_sel #(.N_CH(N_CH)) u_lvl (
    .elig_i(elig), .prio_i(chan_prio_i), .lvl_o(win_lvl),
    .lvl_req_o(lvl_req), .any_o(any_elig)
  );

  dta_rr_pick #(.N_CH(N_CH)) u_rr (
    .req_i(lvl_req), .ptr_i(ptr_q[win_lvl]), .hit_o(win_hit), .idx_o(win_idx)
  );

  // Level of the active channel
  always_comb begin
    act_lvl = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (grant_q[i]) act_lvl = chan_prio_i[i*PRIO_W +: PRIO_W];
    end
  end

  assign act_en  = |(grant_q & chan_en_i);
  assign act_pre = |(grant_q & chan_preempt_i);
  assign win_nxt = (win_idx == IDX_W'(N_CH - 1)) ? '0 : win_idx + 1'b1;

  always_comb begin
    release_c = vld_q && (xfer_done_i || !act_en);
    preempt_c = vld_q && !release_c && xfer_bound_i && act_pre &&
                any_elig && (win_lvl < act_lvl);
    grant_d   = grant_q;
    vld_d     = vld_q;
    ptr_d     = ptr_q;
    issue     = 1'b0;
    if (!vld_q || release_c) begin
      if (any_elig && win_hit) begin
        issue = 1'b1;
      end else begin
        grant_d = '0;
        vld_d   = 1'b0;
      end
    end else if (preempt_c && win_hit) begin
      issue = 1'b1;
    end
    if (issue) begin
      grant_d          = '0;
      grant_d[win_idx] = 1'b1;
      vld_d            = 1'b1;
      ptr_d[win_lvl]   = win_nxt;
    end
    upd = issue || release_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      vld_q   <= 1'b0;
    end else if (upd) begin
      grant_q <= grant_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (issue) begin
      ptr_q <= ptr_d;
    end
  end

  assign grant_o     = grant_q;
  assign grant_vld_o = vld_q;
endmodule

// File: rtl/dta_trigger_arbiter_chk.sv
module dta_trigger_arbiter_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] chan_en_i,
  input logic [N_CH-1:0] chan_preempt_i,
  input logic            xfer_bound_i,
  input logic            xfer_done_i,
  input logic [N_CH-1:0] grant_o,
  input logic            grant_vld_o
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> $onehot(grant_o)); // R2

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld_o |-> (grant_o == '0)); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !xfer_bound_i && !xfer_done_i && |(grant_o & chan_en_i))
    |=> (grant_vld_o && $stable(grant_o))); // R6

  AST_NONPRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !xfer_done_i && !(|(grant_o & chan_preempt_i)) &&
     |(grant_o & chan_en_i))
    |=> (grant_vld_o && $stable(grant_o))); // R6

  AST_DONE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && xfer_done_i) |=> (!grant_vld_o || !$stable(grant_o))); // R7

  AST_NEW_GRANT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !$stable(grant_o)) |-> |(grant_o & $past(chan_en_i))); // R9
endmodule

bind dta_trigger_arbiter dta_trigger_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en_i),
  .chan_preempt_i(chan_preempt_i), .xfer_bound_i(xfer_bound_i),
  .xfer_done_i(xfer_done_i), .grant_o(grant_o), .grant_vld_o(grant_vld_o)
);

// File: tb/sim_dta_trigger_arbiter.sv
module sim_dta_trigger_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NV = 21;
  // Vector: {trig[3:0], bound, done, expected grant[3:0], expected valid}
  localparam logic [10:0] VEC [NV] = '{
    11'b0011_0_0_0000_0, // 1  R1 latch, no grant yet
    11'b0000_0_0_0001_1, // 2  R1 grant ch0
    11'b0000_0_1_0010_1, // 3  R7 done -> ch1 (R4)
    11'b0000_0_1_0000_0, // 4  R7 done -> idle
    11'b0011_0_0_0000_0, // 5
    11'b0000_0_0_0001_1, // 6  R4 wraps past ch2,ch3 to ch0
    11'b1000_0_0_0001_1, // 7  R1 trigger while busy held
    11'b0000_1_0_1000_1, // 8  R5 ch3 level0 preempts ch0 (R3)
    11'b0000_1_0_1000_1, // 9  R6 ch3 non-preemptable
    11'b0000_0_1_0010_1, // 10 R4 pointer gives ch1
    11'b0000_0_1_0001_1, // 11 R8 preempted ch0 resumes
    11'b0100_1_0_0001_1, // 12 R5 nothing pending yet at edge
    11'b0000_1_0_0100_1, // 13 R5 ch2 level1 preempts ch0
    11'b1000_0_0_0100_1, // 14 R1 ch3 latched
    11'b0000_1_0_0100_1, // 15 R6 ch2 holds against level0
    11'b0000_0_1_1000_1, // 16 R3 ch3 beats ch0
    11'b0000_0_1_0001_1, // 17 R8 ch0 again
    11'b0010_0_0_0001_1, // 18
    11'b0000_1_0_0001_1, // 19 R5 equal level no preempt
    11'b0000_0_1_0010_1, // 20 R7
    11'b0000_0_1_0000_0  // 21 R7 idle
  };

  logic clk, rst_n;
  logic [NC-1:0] trig, en, pre, grant;
  logic [2*NC-1:0] prio;
  logic bound, done, vld;
  int n_chk, n_fail;
  bit finished;

  dta_trigger_arbiter #(.N_CH(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .chan_en_i(en),
    .chan_prio_i(prio), .chan_preempt_i(pre), .xfer_bound_i(bound),
    .xfer_done_i(done), .grant_o(grant), .grant_vld_o(vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vec_tag(int k);
    case (k)
      0, 1, 6, 13: return "R1";
      2, 3, 19, 20: return "R7";
      5, 9: return "R4";
      7, 11, 12, 18: return "R5";
      8, 14: return "R6";
      15: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [NC-1:0] eg, input logic ev);
    n_chk++;
    if (grant !== eg || vld !== ev) begin
      n_fail++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b", tag, grant, vld, eg, ev);
    end
    n_chk++;
    if ($countones(grant) != (vld ? 1 : 0)) begin
      n_fail++;
      $display("FAIL R2: grant=%b vld=%b expected one-hot matching valid", grant, vld);
    end
  endtask

  task automatic step(input logic [NC-1:0] t, input logic [NC-1:0] e,
                      input logic b, input logic d,
                      input logic [NC-1:0] eg, input logic ev, input string tag);
    @(negedge clk);
    trig = t; en = e; bound = b; done = d;
    @(posedge clk);
    #1;
    check(tag, eg, ev);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; trig = '0; en = 4'hF; bound = 0; done = 0;
    prio = 8'b00_01_10_10; // ch3=0 ch2=1 ch1=2 ch0=2
    pre  = 4'b0011;        // ch0, ch1 preemptable
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R10", 4'b0000, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [10:0] v;
      v = VEC[k];
      step(v[10:7], 4'hF, v[6], v[5], v[4:1], v[0], vec_tag(k));
    end

    // R9: trigger on disabled channel ignored
    step(4'b0001, 4'b1110, 0, 0, 4'b0000, 1'b0, "R9");
    step(4'b0000, 4'hF,    0, 0, 4'b0000, 1'b0, "R9");
    // R9: disabling a pending channel drops its request
    step(4'b0001, 4'hF,    0, 0, 4'b0000, 1'b0, "R9");
    step(4'b0000, 4'b1110, 0, 0, 4'b0000, 1'b0, "R9");
    step(4'b0000, 4'hF,    0, 0, 4'b0000, 1'b0, "R9");
    step(4'b0000, 4'hF,    0, 0, 4'b0000, 1'b0, "R9");
    // R9: disabling the active channel releases the grant
    step(4'b0010, 4'hF,    0, 0, 4'b0000, 1'b0, "R1");
    step(4'b0000, 4'hF,    0, 0, 4'b0010, 1'b1, "R1");
    step(4'b0000, 4'b1101, 0, 0, 4'b0000, 1'b0, "R9");
    step(4'b0000, 4'hF,    0, 0, 4'b0000, 1'b0, "R9");

    // R10: reset in the middle wipes a pending request
    step(4'b0100, 4'hF,    0, 0, 4'b0000, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b0; trig = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R10", 4'b0000, 1'b0);
    step(4'b0000, 4'hF,    0, 0, 4'b0000, 1'b0, "R10");
    step(4'b0000, 4'hF,    0, 0, 4'b0000, 1'b0, "R10");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule